// File: doc/BRIEF.md
# Byte Handshake Serial Transceiver

This block moves a single byte between a host and a power-management microcontroller over a three-wire link. The peer supplies the shift clock. Two lines carry the handshake, and both are active low: a transfer-request line driven by this block and a transfer-acknowledge line driven by the peer. An upper protocol engine asks the block either to send a byte or to fetch one. The block sets the shift direction, prepares the shift register and pulls the request line low. It then shifts eight bits on the rising edges of the peer's clock, most significant bit first.

Once the eighth bit has moved, the block releases the request line. It then waits for the peer to let its acknowledge line return high. The block reports one of three outcomes, each as a one-cycle pulse: a normal finish, an expiry of the acknowledge wait, or a protocol warning. The warning means the acknowledge line was already high when the byte completed. The peer clock, the peer data and the acknowledge line each pass through a two-flop synchronizer before any logic uses them.

Top module: `hsx_xcvr`

## Requirements
- R1: While reset is held, and after it is released, `req_n` is high, `busy`, `done`, `timeout` and `ack_warn` are low, and `rx_byte` is zero.
- R2: A `start_tx` pulse while idle loads `tx_byte` and drives `req_n` low from the next cycle. `sdata_out` shows the byte most significant bit first. It advances one bit on each rising edge of `sclk_in` that has passed the synchronizer.
- R3: A `start_rx` pulse while idle clears the shift register and drives `req_n` low. `sdata_in` is sampled on each synchronized rising edge of `sclk_in`, first bit into the most significant position. After the eighth edge, `rx_byte` holds the eight bits received.
- R4: The cycle that shifts the eighth bit drives `req_n` high again. `busy` stays high while the block waits for acknowledge.
- R5: While waiting, a synchronized high on `ack_n_in` ends the byte with a one-cycle `done` pulse and a return to idle.
- R6: If `ack_n_in` stays low for `TIMEOUT_CYC` cycles of waiting, the block gives a one-cycle `timeout` pulse instead of `done` and returns to idle.
- R7: If the synchronized `ack_n_in` is already high in the cycle the eighth bit shifts, the block gives a one-cycle `ack_warn` pulse together with the release of `req_n`, and the byte still completes with `done`.
- R8: `start_tx` and `start_rx` are ignored while `busy` is high. A byte in flight continues unchanged.
- R9: If `start_tx` and `start_rx` arrive in the same idle cycle, the transmit request wins.
- R10: `done` and `timeout` are never high in the same cycle, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_tx | input | 1 | Request to transmit `tx_byte` (taken only while idle) |
| start_rx | input | 1 | Request to receive one byte (taken only while idle) |
| tx_byte | input | DATA_W | Byte to transmit |
| sclk_in | input | 1 | Shift clock from the peer (asynchronous) |
| sdata_in | input | 1 | Serial data from the peer |
| sdata_out | output | 1 | Serial data to the peer, most significant bit first |
| ack_n_in | input | 1 | Active-low transfer acknowledge from the peer |
| req_n | output | 1 | Active-low transfer request to the peer |
| busy | output | 1 | High from acceptance of a request until the outcome pulse |
| rx_byte | output | DATA_W | Last received byte |
| done | output | 1 | One-cycle pulse: byte finished normally |
| timeout | output | 1 | One-cycle pulse: acknowledge never returned high |
| ack_warn | output | 1 | One-cycle pulse: acknowledge was already high at completion |

## Verification
Two functions can fall in the same cycle. The eighth-bit completion, which releases `req_n` and may capture `rx_byte`, can coincide with the protocol check on the acknowledge line. The bench provokes this by leaving `ack_n_in` high for a whole transfer, so that the warning, the release and the capture all come from the same clock edge. A second case is a start request that arrives while a byte is in flight. The bench raises both start inputs in the middle of a transfer, to see that neither the shift register nor the direction changes. Every cycle is judged against a behavioural model in the bench. The bytes the peer sees and the outcome pulse counts are checked after each transfer.

// File: rtl/hsx_pkg.sv
package hsx_pkg;
  typedef enum logic [1:0] {
    HSX_IDLE  = 2'd0,
    HSX_SHIFT = 2'd1,
    HSX_WAIT  = 2'd2
  } hsx_state_e;
endpackage

// File: rtl/hsx_sync.sv
module hsx_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d_in;
      stab_q <= meta_q;
    end
  end

  assign q_out = stab_q;
endmodule

// File: rtl/hsx_shifter.sv
module hsx_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_tx,
  input  logic         load_rx,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] shreg,
  output logic         last_bit
);
  localparam int CNT_W = (W > 2) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(W - 1);

  logic [W-1:0]     sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sh_en;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    sh_en = 1'b0;
    if (load_tx) begin
      sh_d  = load_val;
      cnt_d = '0;
      sh_en = 1'b1;
    end else if (load_rx) begin
      sh_d  = '0;
      cnt_d = '0;
      sh_en = 1'b1;
    end else if (shift_en) begin
      sh_d  = {sh_q[W-2:0], bit_in};
      cnt_d = cnt_q + 1'b1;
      sh_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (sh_en) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign shreg    = sh_q;
  assign last_bit = shift_en && (cnt_q == LAST_IDX);
endmodule

// File: rtl/hsx_ack_timer.sv
module hsx_ack_timer #(
  parameter int LIMIT = 4_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] END_CNT = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run)                 cnt_d = '0;
    else if (cnt_q != END_CNT) cnt_d = cnt_q + 1'b1;
    else                      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q == END_CNT);
endmodule

// File: rtl/hsx_xcvr.sv
module hsx_xcvr
  import hsx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TIMEOUT_CYC = 4_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_tx,
  input  logic              start_rx,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              sclk_in,
  input  logic              sdata_in,
  output logic              sdata_out,
  input  logic              ack_n_in,
  output logic              req_n,
  output logic              busy,
  output logic [DATA_W-1:0] rx_byte,
  output logic              done,
  output logic              timeout,
  output logic              ack_warn
);
  localparam int SYNC_W = 3;

  logic [SYNC_W-1:0] sync_q;
  logic sclk_s, sdata_s, ack_s;
  logic sclk_prev_q;
  logic sclk_rise;

  hsx_sync #(.W(SYNC_W), .RST_VAL({SYNC_W{1'b1}})) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({sclk_in, sdata_in, ack_n_in}),
    .q_out (sync_q)
  );

  assign {sclk_s, sdata_s, ack_s} = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b1;
    else        sclk_prev_q <= sclk_s;
  end

  assign sclk_rise = sclk_s && !sclk_prev_q;

  hsx_state_e        state_q, state_d;
  logic              req_n_q, req_n_d;
  logic              dir_tx_q, dir_tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic              rx_en;
  logic              done_q, done_d;
  logic              to_q, to_d;
  logic              warn_q, warn_d;
  logic              load_tx, load_rx, shift_en;
  logic [DATA_W-1:0] shreg;
  logic              last_bit;
  logic              wait_expired;

  hsx_shifter #(.W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_tx  (load_tx),
    .load_rx  (load_rx),
    .load_val (tx_byte),
    .shift_en (shift_en),
    .bit_in   (sdata_s),
    .shreg    (shreg),
    .last_bit (last_bit)
  );

  hsx_ack_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state_q == HSX_WAIT && !ack_s),
    .expired (wait_expired)
  );

  always_comb begin
    state_d  = state_q;
    req_n_d  = req_n_q;
    dir_tx_d = dir_tx_q;
    rx_d     = {shreg[DATA_W-2:0], sdata_s};
    rx_en    = 1'b0;
    done_d   = 1'b0;
    to_d     = 1'b0;
    warn_d   = 1'b0;
    load_tx  = 1'b0;
    load_rx  = 1'b0;
    shift_en = 1'b0;
    unique case (state_q)
      HSX_IDLE: begin
        if (start_tx) begin
          load_tx  = 1'b1;
          dir_tx_d = 1'b1;
          req_n_d  = 1'b0;
          state_d  = HSX_SHIFT;
        end else if (start_rx) begin
          load_rx  = 1'b1;
          dir_tx_d = 1'b0;
          req_n_d  = 1'b0;
          state_d  = HSX_SHIFT;
        end
      end
      HSX_SHIFT: begin
        shift_en = sclk_rise;
        if (last_bit) begin
          req_n_d = 1'b1;
          warn_d  = ack_s;
          rx_en   = !dir_tx_q;
          state_d = HSX_WAIT;
        end
      end
      HSX_WAIT: begin
        if (ack_s) begin
          done_d  = 1'b1;
          state_d = HSX_IDLE;
        end else if (wait_expired) begin
          to_d    = 1'b1;
          state_d = HSX_IDLE;
        end
      end
      default: state_d = HSX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= HSX_IDLE;
      req_n_q  <= 1'b1;
      dir_tx_q <= 1'b0;
      done_q   <= 1'b0;
      to_q     <= 1'b0;
      warn_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      req_n_q  <= req_n_d;
      dir_tx_q <= dir_tx_d;
      done_q   <= done_d;
      to_q     <= to_d;
      warn_q   <= warn_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rx_q <= '0;
    else if (rx_en) rx_q <= rx_d;
  end

  assign sdata_out = dir_tx_q ? shreg[DATA_W-1] : 1'b1;
  assign req_n     = req_n_q;
  assign busy      = (state_q != HSX_IDLE);
  assign rx_byte   = rx_q;
  assign done      = done_q;
  assign timeout   = to_q;
  assign ack_warn  = warn_q;
endmodule

// File: rtl/hsx_xcvr_chk.sv
module hsx_xcvr_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_tx,
  input logic              start_rx,
  input logic [DATA_W-1:0] tx_byte,
  input logic              sdata_out,
  input logic              req_n,
  input logic              busy,
  input logic              done,
  input logic              timeout,
  input logic              ack_warn
);
  // R4
  req_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_n |-> busy);

  // R8
  req_fall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_n) |-> !$past(busy));

  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !busy);

  // R7
  warn_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_warn |-> (req_n && !$past(req_n)));

  // R9
  tx_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_tx && start_rx && !busy) |=> (!req_n && sdata_out == $past(tx_byte[DATA_W-1])));
endmodule

bind hsx_xcvr hsx_xcvr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_tx  (start_tx),
  .start_rx  (start_rx),
  .tx_byte   (tx_byte),
  .sdata_out (sdata_out),
  .req_n     (req_n),
  .busy      (busy),
  .done      (done),
  .timeout   (timeout),
  .ack_warn  (ack_warn)
);

// File: tb/sim_hsx_xcvr.sv
`timescale 1ns/1ps
module sim_hsx_xcvr;
  localparam int TMO = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_tx = 1'b0, start_rx = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic sclk_in = 1'b1, sdata_in = 1'b1, ack_n_in = 1'b1;
  logic sdata_out, req_n, busy, done, timeout, ack_warn;
  logic [7:0] rx_byte;

  int n_chk = 0, n_fail = 0;
  int n_done = 0, n_to = 0, n_warn = 0;

  always #4 clk = ~clk;

  hsx_xcvr #(.DATA_W(8), .TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .start_tx(start_tx), .start_rx(start_rx),
    .tx_byte(tx_byte), .sclk_in(sclk_in), .sdata_in(sdata_in),
    .sdata_out(sdata_out), .ack_n_in(ack_n_in), .req_n(req_n), .busy(busy),
    .rx_byte(rx_byte), .done(done), .timeout(timeout), .ack_warn(ack_warn)
  );

  // behavioural reference: phase 0 idle, 1 shifting, 2 awaiting ack
  int         ph, nbits, nwait;
  bit         m_req, m_done, m_to, m_warn, m_dir;
  bit [7:0]   m_sh, m_rx;
  bit         clk_hist[$], dat_hist[$], ack_hist[$];
  bit         clk_last;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; nbits = 0; nwait = 0;
      m_req = 1; m_done = 0; m_to = 0; m_warn = 0; m_dir = 0;
      m_sh = 0; m_rx = 0;
      clk_hist = '{1, 1}; dat_hist = '{1, 1}; ack_hist = '{1, 1};
      clk_last = 1;
    end else begin
      bit sc, sd, sa, edge_seen;
      sc = clk_hist[1]; sd = dat_hist[1]; sa = ack_hist[1];
      edge_seen = sc && !clk_last;
      m_done = 0; m_to = 0; m_warn = 0;
      if (ph == 0) begin
        if (start_tx) begin
          ph = 1; m_req = 0; m_dir = 1; m_sh = tx_byte; nbits = 0;
        end else if (start_rx) begin
          ph = 1; m_req = 0; m_dir = 0; m_sh = 0; nbits = 0;
        end
      end else if (ph == 1) begin
        if (edge_seen) begin
          if (nbits == 7) begin
            m_req = 1; ph = 2; nwait = 0; m_warn = sa;
            if (!m_dir) m_rx = {m_sh[6:0], sd};
          end
          m_sh = {m_sh[6:0], sd};
          nbits++;
        end
      end else begin
        if (sa) begin m_done = 1; ph = 0; end
        else if (nwait == TMO - 1) begin m_to = 1; ph = 0; end
        else nwait++;
      end
      clk_last = sc;
      clk_hist.pop_back(); clk_hist.push_front(sclk_in);
      dat_hist.pop_back(); dat_hist.push_front(sdata_in);
      ack_hist.pop_back(); ack_hist.push_front(ack_n_in);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check("R1/R4 req_n", {31'd0, req_n}, {31'd0, m_req});
      check("R8 busy", {31'd0, busy}, {31'd0, ph != 0});
      check("R5 done", {31'd0, done}, {31'd0, m_done});
      check("R6 timeout", {31'd0, timeout}, {31'd0, m_to});
      check("R7 ack_warn", {31'd0, ack_warn}, {31'd0, m_warn});
      check("R3 rx_byte", {24'd0, rx_byte}, {24'd0, m_rx});
      check("R2 sdata_out", {31'd0, sdata_out}, {31'd0, m_dir ? m_sh[7] : 1'b1});
      n_done += done; n_to += timeout; n_warn += ack_warn;
    end
  end

  // ack_mode: 0 peer acks and releases, 1 peer never acks, 2 peer holds ack low
  task automatic run_xfer(input bit is_tx, input bit both, input logic [7:0] b,
                          input int ack_mode, input bit poke, output logic [7:0] got);
    got = 8'h00;
    @(negedge clk); #1;
    start_tx = is_tx | both; start_rx = !is_tx | both; tx_byte = b;
    @(negedge clk); #1;
    start_tx = 0; start_rx = 0;
    if (ack_mode != 1) ack_n_in = 0;
    repeat (2) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); #1;
      sclk_in = 0; sdata_in = b[i];
      if (poke && i == 5) begin start_tx = 1; start_rx = 1; tx_byte = ~b; end
      repeat (4) @(negedge clk); #1;
      sclk_in = 1; got[i] = sdata_out;
      start_tx = 0; start_rx = 0;
      repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    if (ack_mode != 1) begin
      check("R4 req_n released while waiting", {31'd0, req_n}, 32'd1);
      check("R4 busy while waiting", {31'd0, busy}, 32'd1);
    end
    if (ack_mode == 0) begin
      #1 ack_n_in = 1; repeat (6) @(negedge clk);
    end else if (ack_mode == 2) begin
      repeat (TMO + 5) @(negedge clk); #1 ack_n_in = 1; repeat (3) @(negedge clk);
    end else begin
      repeat (3) @(negedge clk);
    end
    sdata_in = 1;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] got;
    int d0, t0, w0;
    repeat (2) @(negedge clk);
    check("R1 req_n in reset", {31'd0, req_n}, 32'd1);
    check("R1 busy in reset", {31'd0, busy}, 32'd0);
    #1 rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", {28'd0, busy, done, timeout, ack_warn}, 32'd0);
    check("R1 rx_byte after reset", {24'd0, rx_byte}, 32'd0);

    d0 = n_done;
    run_xfer(1, 0, 8'hA5, 0, 0, got);
    check("R2 peer saw byte", {24'd0, got}, 32'hA5);
    check("R5 one done", n_done - d0, 1);

    d0 = n_done;
    run_xfer(0, 0, 8'h3C, 0, 0, got);
    check("R3 received byte", {24'd0, rx_byte}, 32'h3C);
    check("R5 one done rx", n_done - d0, 1);

    run_xfer(0, 0, 8'hC1, 0, 0, got);
    check("R3 received second byte", {24'd0, rx_byte}, 32'hC1);

    d0 = n_done; t0 = n_to;
    run_xfer(1, 0, 8'h5A, 2, 0, got);
    check("R6 timeout pulse", n_to - t0, 1);
    check("R10 no done on timeout", n_done - d0, 0);
    check("R6 idle after timeout", {31'd0, busy}, 32'd0);

    d0 = n_done; w0 = n_warn;
    run_xfer(0, 0, 8'h96, 1, 0, got);
    check("R7 warn pulse", n_warn - w0, 1);
    check("R7 still done", n_done - d0, 1);
    check("R7 byte still captured", {24'd0, rx_byte}, 32'h96);

    d0 = n_done;
    run_xfer(1, 0, 8'h71, 0, 1, got);
    check("R8 busy start ignored", {24'd0, got}, 32'h71);
    check("R8 single done", n_done - d0, 1);
    check("R8 rx_byte untouched", {24'd0, rx_byte}, 32'h96);

    run_xfer(1, 1, 8'hE8, 0, 0, got);
    check("R9 transmit wins", {24'd0, got}, 32'hE8);
    check("R9 rx_byte untouched", {24'd0, rx_byte}, 32'h96);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule